// File: doc/BRIEF.md
# Reloadable Up/Down Timer Counter

This block is a general-purpose timer with three software-visible registers reached over a simple register bus: a reload register, a read-only current-count register and a control register. It advances its counter on ticks made by dividing the core clock with a selectable prescaler. It can count either down or up. In free-running mode it wraps between zero and full scale. In periodic mode it restarts from the reload register.

Writing the control register is the start action. That write clears the prescaler and presets the counter. Each time the counter wraps or reloads, the block drives a one-cycle timeout pulse, which other logic can use as an event or interrupt source.

Bus access is a single-cycle strobe, `busSel` together with `busWr`. Reads are combinational from `busAddr`. Word addresses are: 0 reload, 1 count (writes ignored), 2 control, 3 reads as zero.

Top module: `reload_timer`

## Requirements
- R1: After reset, the count, reload and control registers all read as zero, the timer is stopped and `timeoutPulse` is low.
- R2: A write to the control register (address 2) presets the counter. Periodic mode presets it to the reload value. Free-running down mode presets it to all ones. Free-running up mode presets it to zero. The new count is readable in the cycle after the write.
- R3: In free-running down mode (control bit 6 = 0, bit 5 = 0), each tick subtracts one. A tick at zero gives all ones.
- R4: In free-running up mode (bit 6 = 0, bit 5 = 1), each tick adds one. A tick at all ones gives zero.
- R5: In periodic down mode (bit 6 = 1, bit 5 = 0), a tick at zero loads the reload value.
- R6: In periodic up mode (bit 6 = 1, bit 5 = 1), a tick at all ones loads the reload value.
- R7: Control bits 3:2 select the tick period: 0 gives 1 cycle, 1 gives 16, 2 gives 256 and 3 gives 32768 cycles. The first step comes that many cycles after the control write.
- R8: `timeoutPulse` is high for exactly the one cycle that follows a wrap or reload tick. It is low at all other times.
- R9: With the enable bit (control bit 7) clear, the count holds its value.
- R10: A write to the reload register (address 0) while the timer runs leaves the current count untouched. The new value is used at the next reload.
- R11: A write to address 1 has no effect. Reads return the reload register at 0, the count at 1, the control register at 2, and zero at 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | Write qualifier for the access |
| busAddr | input | 2 | Register word address |
| busWdata | input | WIDTH | Write data |
| busRdata | output | WIDTH | Read data for `busAddr` |
| timeoutPulse | output | 1 | One-cycle wrap/reload event |

## Verification
The properties assume that at most one register is addressed per cycle, and that the enable, mode and direction bits change only through a control write. The stepping and reload properties depend on this, because they compare the count against its value one cycle earlier. The stimulus drives the bus half a cycle away from the active edge and performs one access at a time. It samples the count and the pulse at the opposite edge, so every expected value follows from counting ticks since the last control write. A narrow counter width makes full-scale wraps reachable in a few hundred cycles.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  localparam int PRE_W   = 15;
  localparam int EN_BIT  = 7;
  localparam int PER_BIT = 6;
  localparam int UP_BIT  = 5;
  localparam int PS_LO   = 2;

  typedef struct packed {
    logic start;
    logic tick;
    logic countUp;
    logic periodic;
  } tmr_strobe_t;

  function automatic logic [PRE_W-1:0] preLimit(input logic [1:0] sel);
    logic [PRE_W-1:0] lim;
    case (sel)
      2'd0:    lim = '0;
      2'd1:    lim = PRE_W'(15);
      2'd2:    lim = PRE_W'(255);
      default: lim = PRE_W'(32767);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  input  logic [WIDTH-1:0] countVal,
  output logic [WIDTH-1:0] busRdata,
  output logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] ctrlVal,
  output tmr_strobe_t      strb
);
  localparam logic [WIDTH-1:0] CTRL_MASK = WIDTH'(8'hEC);

  logic [WIDTH-1:0] loadReg;
  logic [WIDTH-1:0] ctrlReg;
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] lim;
  logic             wrLoad;
  logic             wrCtrl;
  logic             running;

  assign wrLoad  = busSel && busWr && (busAddr == 2'd0);
  assign wrCtrl  = busSel && busWr && (busAddr == 2'd2);
  assign running = ctrlReg[EN_BIT];
  assign lim     = preLimit(ctrlReg[PS_LO+1:PS_LO]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadReg <= '0;
      ctrlReg <= '0;
      presc   <= '0;
    end else begin
      if (wrLoad) loadReg <= busWdata;
      if (wrCtrl) begin
        ctrlReg <= busWdata & CTRL_MASK;
        presc   <= '0;
      end else if (running) begin
        if (presc == lim) presc <= '0;
        else              presc <= presc + 1'b1;
      end
    end
  end

  always_comb begin
    strb.start    = wrCtrl;
    strb.tick     = running && (presc == lim) && !wrCtrl;
    strb.countUp  = wrCtrl ? busWdata[UP_BIT]  : ctrlReg[UP_BIT];
    strb.periodic = wrCtrl ? busWdata[PER_BIT] : ctrlReg[PER_BIT];
  end

  always_comb begin
    case (busAddr)
      2'd0:    busRdata = loadReg;
      2'd1:    busRdata = countVal;
      2'd2:    busRdata = ctrlReg;
      default: busRdata = '0;
    endcase
  end

  assign loadVal = loadReg;
  assign ctrlVal = ctrlReg;
endmodule

// File: rtl/rtimer_dp.sv
module rtimer_dp
  import rtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strb,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] countVal,
  output logic             timeoutPulse
);
  localparam logic [WIDTH-1:0] FULL = '1;

  logic [WIDTH-1:0] cnt;
  logic [WIDTH-1:0] restartVal;
  logic             atLimit;
  logic             pulse;

  assign atLimit = strb.countUp ? (cnt == FULL) : (cnt == '0);

  always_comb begin
    if (strb.periodic)     restartVal = loadVal;
    else if (strb.countUp) restartVal = '0;
    else                   restartVal = FULL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (strb.start) begin
      cnt   <= restartVal;
      pulse <= 1'b0;
    end else if (strb.tick) begin
      if (atLimit) begin
        cnt   <= restartVal;
        pulse <= 1'b1;
      end else begin
        cnt   <= strb.countUp ? cnt + 1'b1 : cnt - 1'b1;
        pulse <= 1'b0;
      end
    end else begin
      pulse <= 1'b0;
    end
  end

  assign countVal     = cnt;
  assign timeoutPulse = pulse;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  output logic             timeoutPulse
);
  tmr_strobe_t      strb;
  logic [WIDTH-1:0] countVal;
  logic [WIDTH-1:0] loadVal;
  logic [WIDTH-1:0] ctrlVal;

  rtimer_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .countVal(countVal),
    .busRdata(busRdata), .loadVal(loadVal), .ctrlVal(ctrlVal), .strb(strb)
  );

  rtimer_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .countVal(countVal), .timeoutPulse(timeoutPulse)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import rtimer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] ctrl,
  input logic [WIDTH-1:0] loadVal,
  input logic             start,
  input logic             tick,
  input logic             pulse
);
  localparam logic [WIDTH-1:0] FULL = '1;

  assert_start_preset_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (cnt == (ctrl[PER_BIT] ? $past(loadVal) : (ctrl[UP_BIT] ? '0 : FULL))));

  assert_down_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !start && !ctrl[UP_BIT] && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !start && ctrl[UP_BIT] && cnt != FULL) |=> (cnt == $past(cnt) + 1'b1));

  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !start && ctrl[PER_BIT] && !ctrl[UP_BIT] && cnt == '0) |=> (cnt == $past(loadVal)));

  assert_periodic_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !start && ctrl[PER_BIT] && ctrl[UP_BIT] && cnt == FULL) |=> (cnt == $past(loadVal)));

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    pulse |-> $past(tick));

  assert_no_tick_stopped_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl[EN_BIT] |-> !tick);

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !start) |=> $stable(cnt));
endmodule

bind reload_timer reload_timer_chk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .cnt(countVal), .ctrl(ctrlVal), .loadVal(loadVal),
  .start(strb.start), .tick(strb.tick), .pulse(timeoutPulse)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  localparam int TW = 8;
  localparam int NV = 28;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [7:0]  data;
    logic [15:0] waitN;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    '{1'b1, 2'd0, 8'd5,    16'd0,  8'd0,   4'd0},   // reload = 5
    '{1'b1, 2'd2, 8'hC0,   16'd0,  8'd0,   4'd0},   // periodic down, div 1
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd5,   4'd2},   // R2 preset from reload
    '{1'b0, 2'd1, 8'd0,    16'd3,  8'd2,   4'd5},   // R5 stepping down
    '{1'b0, 2'd1, 8'd0,    16'd2,  8'd0,   4'd5},
    '{1'b0, 2'd1, 8'd0,    16'd1,  8'd5,   4'd5},   // R5 reload at zero
    '{1'b1, 2'd2, 8'hA0,   16'd0,  8'd0,   4'd0},   // free up
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd0,   4'd2},   // R2 preset zero
    '{1'b0, 2'd1, 8'd0,    16'd10, 8'd10,  4'd4},   // R4 stepping up
    '{1'b1, 2'd2, 8'h80,   16'd0,  8'd0,   4'd0},   // free down
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd255, 4'd2},   // R2 preset all ones
    '{1'b0, 2'd1, 8'd0,    16'd1,  8'd254, 4'd3},   // R3 stepping down
    '{1'b1, 2'd0, 8'd250,  16'd0,  8'd0,   4'd0},
    '{1'b1, 2'd2, 8'hE0,   16'd0,  8'd0,   4'd0},   // periodic up
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd250, 4'd2},
    '{1'b0, 2'd1, 8'd0,    16'd5,  8'd255, 4'd6},   // R6 reaches full scale
    '{1'b0, 2'd1, 8'd0,    16'd1,  8'd250, 4'd6},   // R6 reload
    '{1'b1, 2'd2, 8'hC4,   16'd0,  8'd0,   4'd0},   // periodic down, div 16
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd250, 4'd7},
    '{1'b0, 2'd1, 8'd0,    16'd15, 8'd250, 4'd7},   // R7 no step before 16
    '{1'b0, 2'd1, 8'd0,    16'd1,  8'd249, 4'd7},   // R7 step at 16
    '{1'b0, 2'd2, 8'd0,    16'd0,  8'hC4,  4'd11},  // R11 control readback
    '{1'b0, 2'd3, 8'd0,    16'd0,  8'd0,   4'd11},  // R11 unused address
    '{1'b0, 2'd0, 8'd0,    16'd0,  8'd250, 4'd11},  // R11 reload readback
    '{1'b1, 2'd2, 8'h40,   16'd0,  8'd0,   4'd0},   // stopped periodic
    '{1'b0, 2'd1, 8'd0,    16'd20, 8'd250, 4'd9},   // R9 holds
    '{1'b1, 2'd1, 8'h33,   16'd0,  8'd0,   4'd0},   // write to count address
    '{1'b0, 2'd1, 8'd0,    16'd0,  8'd250, 4'd11}   // R11 write ignored
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [1:0]    busAddr = '0;
  logic [TW-1:0] busWdata = '0;
  logic [TW-1:0] busRdata;
  logic          timeoutPulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  reload_timer #(.WIDTH(TW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .timeoutPulse(timeoutPulse)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    total = total + 1;
    if (actual != expected) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [TW-1:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [TW-1:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [TW-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(2'd0, rd); check("R1 reload", rd, 0);
    busRead(2'd1, rd); check("R1 count", rd, 0);
    busRead(2'd2, rd); check("R1 control", rd, 0);
    check("R1 pulse", timeoutPulse, 0);
    waitCyc(5);
    busRead(2'd1, rd); check("R1 stays stopped", rd, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        busWrite(VECS[i].addr, VECS[i].data);
      end else begin
        waitCyc(int'(VECS[i].waitN));
        busRead(VECS[i].addr, rd);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // R3 and R8: free-running down wrap
    busWrite(2'd2, 8'h80);
    waitCyc(255);
    busRead(2'd1, rd); check("R3 at zero", rd, 0);
    check("R8 no pulse before wrap", timeoutPulse, 0);
    waitCyc(1);
    busRead(2'd1, rd); check("R3 wrap to full", rd, 255);
    check("R8 pulse on wrap", timeoutPulse, 1);
    waitCyc(1);
    check("R8 pulse one cycle", timeoutPulse, 0);
    busRead(2'd1, rd); check("R3 continue", rd, 254);

    // R4 and R8: free-running up wrap
    busWrite(2'd2, 8'hA0);
    waitCyc(255);
    busRead(2'd1, rd); check("R4 at full", rd, 255);
    check("R8 no pulse at full", timeoutPulse, 0);
    waitCyc(1);
    busRead(2'd1, rd); check("R4 wrap to zero", rd, 0);
    check("R8 pulse on up wrap", timeoutPulse, 1);

    // R10: reload write mid-run
    busWrite(2'd0, 8'd10);
    busWrite(2'd2, 8'hC0);
    busWrite(2'd0, 8'd4);
    busRead(2'd1, rd); check("R10 count untouched", rd, 9);
    waitCyc(9);
    busRead(2'd1, rd); check("R10 reach zero", rd, 0);
    waitCyc(1);
    busRead(2'd1, rd); check("R10 new reload used", rd, 4);
    check("R8 pulse on reload", timeoutPulse, 1);
    waitCyc(1);
    check("R8 pulse cleared", timeoutPulse, 0);

    // R7: divide by 256 and 32768
    busWrite(2'd2, 8'hC8);
    waitCyc(255);
    busRead(2'd1, rd); check("R7 div256 hold", rd, 4);
    waitCyc(1);
    busRead(2'd1, rd); check("R7 div256 step", rd, 3);
    busWrite(2'd2, 8'hCC);
    waitCyc(32767);
    busRead(2'd1, rd); check("R7 div32768 hold", rd, 4);
    waitCyc(1);
    busRead(2'd1, rd); check("R7 div32768 step", rd, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule